// File: doc/BRIEF.md
# Configuration Memory Load Controller

This block fills a small on-chip configuration memory from one of several external sources. After any reset it first sweeps the whole memory to zero, one word per clock. On the last clear cycle it samples three mode pins and commits to one transfer style until the next reset. The styles are: a self-clocked serial load in which the block paces the bit stream; a serial stream paced by the source; a parallel word stream; a parallel load in which the block supplies the read address of an external ROM; and a direct write port that carries its own address. Two pin codes are reserved and park the block with an error flag raised.

In the self-addressed styles, words land at consecutive locations starting from zero. Serial bits are packed most-significant first into a word, and the word is written once it is full. Once a preset number of words has been accepted the block raises done, drops busy and ignores further traffic until it is reset again. Each data input is a valid/ready stream. A transfer happens on a clock edge where both are high. Ready is a function of state only and never of valid. A source may hold valid high for any number of cycles and must keep its data steady until the transfer happens. A combinational readback port exposes any memory word.

Top module: `cfg_load_ctrl`

## Requirements
- R1: While rst_n is low, and for exactly DEPTH clocks after it rises, the block is clearing: busy is high, every ready and cfg_clk_out are low, and afterwards every memory word reads zero.
- R2: mode_pins are sampled on the last clear clock only; later changes have no effect until the next reset.
- R3: Code 000 (self-clocked serial): cfg_clk_oe is high, and cfg_clk_out is high on every clock of the download. ser_bit is captured on each such clock.
- R4: Codes 001 and 111 (source-paced serial): one bit moves per ser_valid/ser_ready transfer. Bits are packed MSB first, so the first bit of a word lands in bit WORD_W-1.
- R5: Code 010 (parallel stream): one word moves per par_valid/par_ready transfer.
- R6: Code 110 (ROM-addressed parallel): rom_req is high during the download and rom_addr equals the index of the word being fetched, starting at 0. The word returns on the par_valid/par_ready stream.
- R7: Code 100 (direct write): each ram_valid/ram_ready transfer writes ram_data at ram_addr. A transfer whose address is DEPTH or above is counted but writes nothing.
- R8: Codes 011 and 101 are reserved: mode_err rises and stays high, busy is low, and no ready is raised.
- R9: Self-addressed modes write word k at address k. After LOAD_WORDS transfers done is high, busy is low and all readies are low, and inputs offered then change no memory word.
- R10: busy is high exactly while clearing or downloading, and cfg_clk_oe is low in every mode except 000.
- R11: rd_data shows the memory word at rd_addr in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (power-on and manual); starts a clear sweep |
| mode_pins | input | 3 | Transfer mode select |
| cfg_clk_out | output | 1 | Configuration bit clock driven in self-clocked serial mode |
| cfg_clk_oe | output | 1 | High when the block drives the configuration clock |
| ser_bit | input | 1 | Serial configuration data |
| ser_valid | input | 1 | Serial bit valid (source-paced serial) |
| ser_ready | output | 1 | Serial bit accepted when high together with ser_valid |
| par_data | input | WORD_W | Parallel configuration word |
| par_valid | input | 1 | Parallel word valid |
| par_ready | output | 1 | Parallel word accepted when high together with par_valid |
| rom_addr | output | ROM_AW | Word address offered to the external ROM |
| rom_req | output | 1 | rom_addr is meaningful |
| ram_addr | input | RAM_AW | Direct write address |
| ram_data | input | WORD_W | Direct write data |
| ram_valid | input | 1 | Direct write valid |
| ram_ready | output | 1 | Direct write accepted when high together with ram_valid |
| rd_addr | input | MEM_AW | Readback address |
| rd_data | output | WORD_W | Readback data |
| busy | output | 1 | Clearing or downloading |
| done | output | 1 | Preset word count reached |
| mode_err | output | 1 | Reserved mode code sampled |

## Verification
The properties assume that rst_n is the only way back to the clear sweep. They also assume that, in the ROM-addressed mode, a word returned on the parallel stream belongs to the address shown in that cycle. The stimulus drives only the stream that belongs to the sampled mode during a download and keeps data steady while valid waits for ready. In self-clocked serial mode it changes ser_bit only between clock pulses. The mode pins are changed only before the clear ends, except in the one test that checks they are ignored, and traffic offered after done is sent only to confirm it has no effect.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;
  typedef enum logic [2:0] {
    MD_MSER, MD_SSER, MD_SPAR, MD_EPROM, MD_RAM, MD_BAD
  } xfer_mode_e;

  typedef enum logic [1:0] {
    ST_CLEAR, ST_LOAD, ST_IDLE
  } ctl_state_e;
endpackage

// File: rtl/cfg_mode_decode.sv
module cfg_mode_decode
  import cfg_load_pkg::*;
(
  input  logic [2:0]  pins,
  output xfer_mode_e  mode
);
  always_comb begin
    unique case (pins)
      3'b000:         mode = MD_MSER;
      3'b001, 3'b111: mode = MD_SSER;
      3'b010:         mode = MD_SPAR;
      3'b110:         mode = MD_EPROM;
      3'b100:         mode = MD_RAM;
      default:        mode = MD_BAD;
    endcase
  end
endmodule

// File: rtl/cfg_bit_packer.sv
module cfg_bit_packer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         bit_in,
  output logic         word_done,
  output logic [W-1:0] word
);
  localparam int BW = $clog2(W);

  logic [BW-1:0] cnt;
  logic [W-2:0]  sh;

  // MSB first: earlier bits sit higher in the word
  assign word      = {sh, bit_in};
  assign word_done = bit_en && (cnt == BW'(W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sh  <= '0;
    end else if (bit_en) begin
      sh  <= word[W-2:0];
      cnt <= word_done ? '0 : cnt + BW'(1);
    end
  end
endmodule

// File: rtl/cfg_mem.sv
module cfg_mem #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[wa] <= wd;
  end

  assign rd = words[ra];
endmodule

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl
  import cfg_load_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int DEPTH      = 16,
  parameter int LOAD_WORDS = DEPTH,
  parameter int ROM_AW     = 20,
  parameter int RAM_AW     = 24,
  localparam int MEM_AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_pins,
  output logic              cfg_clk_out,
  output logic              cfg_clk_oe,
  input  logic              ser_bit,
  input  logic              ser_valid,
  output logic              ser_ready,
  input  logic [WORD_W-1:0] par_data,
  input  logic              par_valid,
  output logic              par_ready,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_req,
  input  logic [RAM_AW-1:0] ram_addr,
  input  logic [WORD_W-1:0] ram_data,
  input  logic              ram_valid,
  output logic              ram_ready,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic              mode_err
);
  localparam int CNT_W = $clog2(LOAD_WORDS + 1);

  ctl_state_e         state;
  xfer_mode_e         mode_q, mode_dec;
  logic [MEM_AW-1:0]  clr_ptr;
  logic [CNT_W-1:0]   word_cnt;
  logic               in_load, bit_en, pk_done, par_fire, ram_fire, word_wr;
  logic               ram_in_range;
  logic [WORD_W-1:0]  pk_word;
  logic               mem_we;
  logic [MEM_AW-1:0]  mem_wa;
  logic [WORD_W-1:0]  mem_wd;

  cfg_mode_decode u_dec (.pins(mode_pins), .mode(mode_dec));

  assign in_load     = (state == ST_LOAD);
  assign cfg_clk_out = in_load && (mode_q == MD_MSER);
  assign cfg_clk_oe  = (mode_q == MD_MSER);
  assign ser_ready   = in_load && (mode_q == MD_SSER);
  assign par_ready   = in_load && ((mode_q == MD_SPAR) || (mode_q == MD_EPROM));
  assign ram_ready   = in_load && (mode_q == MD_RAM);
  assign rom_req     = in_load && (mode_q == MD_EPROM);
  assign rom_addr    = ROM_AW'(word_cnt);
  assign busy        = (state != ST_IDLE);

  assign bit_en       = cfg_clk_out || (ser_valid && ser_ready);
  assign par_fire     = par_valid && par_ready;
  assign ram_fire     = ram_valid && ram_ready;
  assign word_wr      = pk_done || par_fire || ram_fire;
  assign ram_in_range = (ram_addr < RAM_AW'(DEPTH));

  cfg_bit_packer #(.W(WORD_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(ser_bit),
    .word_done(pk_done), .word(pk_word)
  );

  always_comb begin
    mem_we = 1'b0;
    mem_wa = word_cnt[MEM_AW-1:0];
    mem_wd = '0;
    if (state == ST_CLEAR) begin
      mem_we = 1'b1;
      mem_wa = clr_ptr;
    end else if (pk_done) begin
      mem_we = 1'b1;
      mem_wd = pk_word;
    end else if (par_fire) begin
      mem_we = 1'b1;
      mem_wd = par_data;
    end else if (ram_fire) begin
      mem_we = ram_in_range;
      mem_wa = ram_addr[MEM_AW-1:0];
      mem_wd = ram_data;
    end
  end

  cfg_mem #(.W(WORD_W), .DEPTH(DEPTH), .AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .wa(mem_wa), .wd(mem_wd),
    .ra(rd_addr), .rd(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_CLEAR;
      clr_ptr  <= '0;
      word_cnt <= '0;
      mode_q   <= MD_BAD;
      done     <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      unique case (state)
        ST_CLEAR: begin
          if (clr_ptr == MEM_AW'(DEPTH - 1)) begin
            mode_q <= mode_dec;
            if (mode_dec == MD_BAD) begin
              state    <= ST_IDLE;
              mode_err <= 1'b1;
            end else begin
              state <= ST_LOAD;
            end
          end else begin
            clr_ptr <= clr_ptr + MEM_AW'(1);
          end
        end
        ST_LOAD: begin
          if (word_wr) begin
            word_cnt <= word_cnt + CNT_W'(1);
            if (word_cnt == CNT_W'(LOAD_WORDS - 1)) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_load_ctrl_chk.sv
module cfg_load_ctrl_chk #(
  parameter int DEPTH  = 16,
  parameter int ROM_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mode_err,
  input logic              ser_ready,
  input logic              par_ready,
  input logic              ram_ready,
  input logic              cfg_clk_out,
  input logic              rom_req,
  input logic              par_valid,
  input logic [ROM_AW-1:0] rom_addr
);
  localparam int RC_W = $clog2(DEPTH + 1);
  logic [RC_W-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != RC_W'(DEPTH)) since_rst <= since_rst + RC_W'(1);
  end

  p_clear_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < RC_W'(DEPTH)) |-> (busy && !ser_ready && !par_ready && !ram_ready && !cfg_clk_out));

  p_single_port_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ser_ready, par_ready, ram_ready, cfg_clk_out}));

  p_rom_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_req && par_valid && par_ready) |=> (!rom_req || rom_addr == $past(rom_addr) + ROM_AW'(1)));

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> (!busy && !done));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |=> mode_err);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !ser_ready && !par_ready && !ram_ready));

  p_done_after_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ser_ready && !par_ready && !ram_ready && !cfg_clk_out && !rom_req));
endmodule

bind cfg_load_ctrl cfg_load_ctrl_chk #(.DEPTH(DEPTH), .ROM_AW(ROM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mode_err(mode_err),
  .ser_ready(ser_ready), .par_ready(par_ready), .ram_ready(ram_ready),
  .cfg_clk_out(cfg_clk_out), .rom_req(rom_req), .par_valid(par_valid),
  .rom_addr(rom_addr)
);

// File: tb/cfg_load_ctrl_test.sv
module cfg_load_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORD_W     = 8;
  localparam int DEPTH      = 16;
  localparam int LOAD_WORDS = 16;
  localparam int ROM_AW     = 20;
  localparam int RAM_AW     = 24;
  localparam int MEM_AW     = $clog2(DEPTH);
  localparam int NVEC       = 8;

  // {mode_pins, expect_error, seed}
  localparam logic [11:0] VEC [NVEC] = '{
    {3'b000, 1'b0, 8'h3C}, {3'b001, 1'b0, 8'h5A}, {3'b111, 1'b0, 8'hC3},
    {3'b010, 1'b0, 8'h17}, {3'b110, 1'b0, 8'h81}, {3'b100, 1'b0, 8'hE4},
    {3'b011, 1'b1, 8'h00}, {3'b101, 1'b1, 8'h00}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [2:0]        mode_pins = 3'b010;
  logic              cfg_clk_out, cfg_clk_oe;
  logic              ser_bit = 1'b0, ser_valid = 1'b0, ser_ready;
  logic [WORD_W-1:0] par_data = '0;
  logic              par_valid = 1'b0, par_ready;
  logic [ROM_AW-1:0] rom_addr;
  logic              rom_req;
  logic [RAM_AW-1:0] ram_addr = '0;
  logic [WORD_W-1:0] ram_data = '0;
  logic              ram_valid = 1'b0, ram_ready;
  logic [MEM_AW-1:0] rd_addr = '0;
  logic [WORD_W-1:0] rd_data;
  logic              busy, done, mode_err;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_load_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LOAD_WORDS(LOAD_WORDS),
                  .ROM_AW(ROM_AW), .RAM_AW(RAM_AW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_pins(mode_pins),
    .cfg_clk_out(cfg_clk_out), .cfg_clk_oe(cfg_clk_oe),
    .ser_bit(ser_bit), .ser_valid(ser_valid), .ser_ready(ser_ready),
    .par_data(par_data), .par_valid(par_valid), .par_ready(par_ready),
    .rom_addr(rom_addr), .rom_req(rom_req),
    .ram_addr(ram_addr), .ram_data(ram_data), .ram_valid(ram_valid), .ram_ready(ram_ready),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .mode_err(mode_err)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] pat(input logic [7:0] seed, input int i);
    return WORD_W'(seed + i * 29) ^ WORD_W'(i << 5);
  endfunction

  task automatic read_mem(input int a, output logic [WORD_W-1:0] v);
    rd_addr = MEM_AW'(a);
    #1;
    v = rd_data;
  endtask

  // reset, then stop at the negedge right after the clear sweep ends
  task automatic reset_to(input logic [2:0] m);
    @(negedge clk);
    rst_n = 1'b0;
    mode_pins = m;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (DEPTH) @(negedge clk);
  endtask

  task automatic send_word(input logic [2:0] m, input logic [WORD_W-1:0] w, input int i);
    if (m == 3'b000) begin
      for (int b = WORD_W - 1; b >= 0; b--) begin
        if (cfg_clk_out !== 1'b1) chk("R3", "cfg_clk_out during download", cfg_clk_out, 1);
        ser_bit = w[b];
        @(negedge clk);
      end
    end else if (m == 3'b001 || m == 3'b111) begin
      for (int b = WORD_W - 1; b >= 0; b--) begin
        if (b == 3 && i[0]) begin
          ser_valid = 1'b0;
          @(negedge clk);
        end
        ser_valid = 1'b1;
        ser_bit = w[b];
        while (!ser_ready) @(negedge clk);
        @(negedge clk);
      end
      ser_valid = 1'b0;
    end else if (m == 3'b100) begin
      ram_valid = 1'b1;
      ram_data = w;
      ram_addr = RAM_AW'(DEPTH - 1 - i);
      while (!ram_ready) @(negedge clk);
      @(negedge clk);
      ram_valid = 1'b0;
    end else begin
      par_valid = 1'b1;
      par_data = w;
      while (!par_ready) @(negedge clk);
      if (m == 3'b110) begin
        if (rom_req !== 1'b1 || rom_addr !== ROM_AW'(i)) begin
          chk("R6", "rom_req", rom_req, 1);
          chk("R6", "rom_addr", rom_addr, i);
        end
      end
      @(negedge clk);
      par_valid = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    tests++;
    fails++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [WORD_W-1:0] v;
    logic [2:0] m;
    logic [7:0] seed;
    bit ok;

    // reset state
    #(CLK_PERIOD * 2 + 1);
    chk("R1", "busy in reset", busy, 1);
    chk("R1", "readies in reset", {ser_ready, par_ready, ram_ready, cfg_clk_out}, 0);
    chk("R9", "done in reset", done, 0);
    chk("R8", "mode_err in reset", mode_err, 0);

    // vector table
    for (int e = 0; e < NVEC; e++) begin
      m = VEC[e][11:9];
      seed = VEC[e][7:0];
      reset_to(m);
      chk("R10", "cfg_clk_oe per mode", cfg_clk_oe, (m == 3'b000));
      if (VEC[e][8]) begin
        chk("R8", "mode_err reserved code", mode_err, 1);
        chk("R8", "busy reserved code", busy, 0);
        chk("R8", "readies reserved code", {ser_ready, par_ready, ram_ready, cfg_clk_out}, 0);
        ok = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
          read_mem(a, v);
          if (v !== '0) ok = 1'b0;
        end
        chk("R1", "memory zero after clear", ok, 1);
      end else begin
        chk("R10", "busy in download", busy, 1);
        chk("R2", "mode_err valid code", mode_err, 0);
        for (int i = 0; i < LOAD_WORDS; i++) send_word(m, pat(seed, i), i);
        chk("R9", "done after count", done, 1);
        chk("R9", "busy after count", busy, 0);
        chk("R9", "readies after count", {ser_ready, par_ready, ram_ready, cfg_clk_out, rom_req}, 0);
        for (int a = 0; a < DEPTH; a++) begin
          read_mem(a, v);
          chk((m == 3'b100) ? "R7" : (m == 3'b010 || m == 3'b110) ? "R5" : "R4",
              "word at address", v, pat(seed, (m == 3'b100) ? (DEPTH - 1 - a) : a));
        end
      end
    end

    // reset during a download: clear timing and zeroing
    reset_to(3'b010);
    for (int i = 0; i < 3; i++) send_word(3'b010, 8'hF0 + WORD_W'(i), i);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "busy held in reset", busy, 1);
    rst_n = 1'b1;
    repeat (DEPTH - 1) @(negedge clk);
    chk("R1", "still clearing at DEPTH-1", {busy, par_ready}, 2'b10);
    @(negedge clk);
    chk("R1", "ready after DEPTH clocks", par_ready, 1);
    chk("R9", "done cleared by reset", done, 0);
    ok = 1'b1;
    for (int a = 0; a < DEPTH; a++) begin
      read_mem(a, v);
      if (v !== '0) ok = 1'b0;
    end
    chk("R1", "memory zero after manual reset", ok, 1);

    // mode pins changed after sampling
    reset_to(3'b010);
    mode_pins = 3'b011;
    @(negedge clk);
    chk("R2", "mode_err after late change", mode_err, 0);
    chk("R2", "par_ready after late change", par_ready, 1);
    for (int i = 0; i < LOAD_WORDS; i++) send_word(3'b010, pat(8'h66, i), i);
    chk("R2", "done with late change", done, 1);
    read_mem(5, v);
    chk("R2", "word 5 with late change", v, pat(8'h66, 5));

    // direct write with an out-of-range address last
    reset_to(3'b100);
    for (int j = 0; j < LOAD_WORDS - 1; j++) begin
      ram_valid = 1'b1;
      ram_addr = RAM_AW'(j);
      ram_data = WORD_W'(j + 1);
      while (!ram_ready) @(negedge clk);
      @(negedge clk);
    end
    ram_addr = RAM_AW'(2 * DEPTH - 1);
    ram_data = 8'hA5;
    while (!ram_ready) @(negedge clk);
    @(negedge clk);
    ram_valid = 1'b0;
    chk("R7", "done counts out-of-range word", done, 1);
    read_mem(DEPTH - 1, v);
    chk("R7", "out-of-range not written", v, 0);
    read_mem(0, v);
    chk("R11", "readback word 0", v, 1);

    // traffic after done is ignored
    par_valid = 1'b1; par_data = 8'hFF;
    ram_valid = 1'b1; ram_addr = '0; ram_data = 8'hFF;
    ser_valid = 1'b1; ser_bit = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "readies low after done", {ser_ready, par_ready, ram_ready}, 0);
    par_valid = 1'b0; ram_valid = 1'b0; ser_valid = 1'b0;
    read_mem(0, v);
    chk("R9", "word 0 unchanged after done", v, 1);
    read_mem(1, v);
    chk("R11", "readback word 1", v, 2);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule